// File: doc/BRIEF.md
# Eight-Stream Peripheral-to-Memory DMA Request Scheduler

This block is the control core of a small DMA engine that moves words from peripherals into memory. It has eight streams, and each stream owns a private eight-word FIFO. A stream is bound to one of eight peripheral request lines by a channel field. Words offered on that line are pushed into the stream's FIFO. When the FIFO holds enough words, the stream asks for the single memory-side write port. A fixed-priority arbiter gives that port to the lowest-numbered requesting stream. The winner then drains a burst of words without interruption.

Each stream is set up through a register-style write port. The fields are enable, channel, fill threshold, destination address and word count. Each written word moves the stream's address forward by four bytes and lowers its count by one. When the count reaches zero, the stream flags completion and switches itself off. The peripheral side and the memory side are separate ports, so one stream can fill while another drains.

Configuration port layout. `cfg_sel` picks one of four registers of the stream named by `cfg_stream`:
- 0 is control: bit 0 enable, bits 3:1 channel, bits 5:4 threshold.
- 1 is the start byte address.
- 2 is the word count.
- 3 is status, where writing 1 to bit 0 clears done and writing 1 to bit 1 clears overrun.

Top module: `dma_sched`

## Requirements
- R1: After reset all streams are disabled, `mem_valid`, `per_ready`, `stream_en`, `stream_done` and `stream_overrun` are all 0.
- R2: An enabled stream takes words from the channel in its control bits 3:1, and `per_ready[c]` is 1 exactly when some enabled stream is mapped to channel c (the lowest such stream takes the word).
- R3: When several streams request the memory port in the same cycle, the lowest-numbered one is granted.
- R4: Threshold code 00 means 2 words, 01 means 4 and 10 means 6; code 11 also means 6. A stream requests the memory port only once its FIFO level reaches its burst length, which is the threshold or the remaining count, whichever is smaller.
- R5: A granted stream writes exactly its burst length of words before any other grant is made, and it holds address and data stable while `mem_ready` is low.
- R6: The words of a stream are written in arrival order, to addresses starting at its start address and rising by 4 per word.
- R7: Each written word lowers the stream's count by one. When the count reaches zero the stream sets `stream_done` and clears its enable.
- R8: A word that arrives for a full FIFO is dropped and sets the stream's sticky overrun flag. Writing 1 to status bit 1 clears the overrun flag, and writing 1 to status bit 0 clears done.
- R9: A disabled stream leaves its channel not ready, never requests the memory port, and has its FIFO emptied, so words held before disabling are never written.
- R10: A stream can accept a peripheral word in the same cycle that it writes a word to memory, and neither word is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stream | input | 3 | Stream addressed by the write |
| cfg_sel | input | 2 | Register select: control, address, count, status |
| cfg_wdata | input | 32 | Write data |
| per_valid | input | 8 | Per-channel word-valid lines |
| per_data | input | 256 | Per-channel words, channel c at bits 32c+31:32c |
| per_ready | output | 8 | Channel c has an enabled stream mapped to it |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the word this cycle |
| mem_addr | output | 32 | Byte address of the word |
| mem_data | output | 32 | Word being written |
| mem_stream | output | 3 | Stream currently owning the memory port |
| stream_en | output | 8 | Enable bit of each stream |
| stream_done | output | 8 | Sticky completion flag of each stream |
| stream_overrun | output | 8 | Sticky overrun flag of each stream |

## Verification
The coincidence that matters most is a stream filling and draining at once. Its peripheral channel pushes a word in the same cycle that the memory port pops the head of the same FIFO. The bench provokes this by streaming eight words back to back into a stream with a four-word threshold and `mem_ready` held high, so the second half arrives while the first burst is leaving. It judges the result from the memory log: exactly eight words, in arrival order, at consecutive addresses, followed by the done flag. A second overlap tests arbitration against filling. Two streams reach their thresholds on the same edge, and the log must show the lower one's whole burst before the higher one's.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
    localparam int NSTR  = 8;
    localparam int NCH   = 8;
    localparam int DW    = 32;
    localparam int AW    = 32;
    localparam int CW    = 16;
    localparam int DEPTH = 8;
    localparam int SW    = $clog2(NSTR);
    localparam int CHW   = $clog2(NCH);
    localparam int LW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic           en;
        logic [CHW-1:0] chan;
        logic [1:0]     thr;
        logic [AW-1:0]  addr;
        logic [CW-1:0]  cnt;
        logic           done;
        logic           ovr;
    } stream_regs_t;
endpackage

// File: rtl/dma_stream_fifo.sv
module dma_stream_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic [DW-1:0]                wdata,
    output logic [DW-1:0]                rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [LW-1:0] lvl;
    } fifo_state_t;

    fifo_state_t   f_q, f_d;
    logic [DW-1:0] store_q [DEPTH];

    always_comb begin
        f_d = f_q;
        if (flush) begin
            f_d = '0;
        end else begin
            if (push) f_d.wp = (f_q.wp == PW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
            if (pop)  f_d.rp = (f_q.rp == PW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
            f_d.lvl = f_q.lvl + LW'(push) - LW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) store_q[f_q.wp] <= wdata;
    end

    assign rdata = store_q[f_q.rp];
    assign level = f_q.lvl;

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> (f_q.lvl < LW'(DEPTH)));
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> (f_q.lvl != '0));
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          req,
    output logic [N-1:0]          gnt_oh,
    output logic [$clog2(N)-1:0]  gnt_idx,
    output logic                  gnt_any
);
    localparam int IW = $clog2(N);

    always_comb begin
        gnt_oh  = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_oh    = '0;
                gnt_oh[i] = 1'b1;
                gnt_idx   = IW'(i);
                gnt_any   = 1'b1;
            end
        end
    end

    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh) && (gnt_any == (req != '0)));
    p_lowest_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any |-> ((req & (gnt_oh - N'(1))) == '0) && ((gnt_oh & req) != '0));
endmodule

// File: rtl/dma_sched.sv
module dma_sched
    import dma_sched_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SW-1:0]        cfg_stream,
    input  logic [1:0]           cfg_sel,
    input  logic [31:0]          cfg_wdata,
    input  logic [NCH-1:0]       per_valid,
    input  logic [NCH*DW-1:0]    per_data,
    output logic [NCH-1:0]       per_ready,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_data,
    output logic [SW-1:0]        mem_stream,
    output logic [NSTR-1:0]      stream_en,
    output logic [NSTR-1:0]      stream_done,
    output logic [NSTR-1:0]      stream_overrun
);
    typedef struct packed {
        stream_regs_t [NSTR-1:0] st;
        logic                    busy;
        logic [SW-1:0]           gnt;
        logic [LW-1:0]           left;
    } core_state_t;

    core_state_t     c_q, c_d;
    logic [LW-1:0]   lvl    [NSTR];
    logic [DW-1:0]   head   [NSTR];
    logic [DW-1:0]   inword [NSTR];
    logic [LW-1:0]   burst  [NSTR];
    logic [NSTR-1:0] take, fpush, fpop, fflush, req, arb_oh;
    logic [NCH-1:0]  claimed;
    logic [SW-1:0]   arb_idx;
    logic            arb_any, fire;

    function automatic logic [LW-1:0] thr_words(input logic [1:0] code);
        case (code)
            2'b00:   return LW'(DEPTH / 4);
            2'b01:   return LW'(DEPTH / 2);
            default: return LW'((3 * DEPTH) / 4);
        endcase
    endfunction

    // channel routing, burst length and request per stream
    always_comb begin
        claimed = '0;
        take    = '0;
        for (int s = 0; s < NSTR; s++) begin
            inword[s] = per_data[c_q.st[s].chan * DW +: DW];
            if (c_q.st[s].en && !claimed[c_q.st[s].chan]) begin
                claimed[c_q.st[s].chan] = 1'b1;
                take[s] = per_valid[c_q.st[s].chan];
            end
            fpush[s]  = take[s] && (lvl[s] != LW'(DEPTH));
            fflush[s] = !c_q.st[s].en;
            if (c_q.st[s].cnt < CW'(thr_words(c_q.st[s].thr)))
                burst[s] = c_q.st[s].cnt[LW-1:0];
            else
                burst[s] = thr_words(c_q.st[s].thr);
            req[s] = c_q.st[s].en && (c_q.st[s].cnt != '0) && (lvl[s] >= burst[s]);
        end
        fire = c_q.busy && mem_ready;
        fpop = '0;
        if (fire) fpop[c_q.gnt] = 1'b1;
    end

    // next state: status clear, datapath events, grant, then register writes
    always_comb begin
        c_d = c_q;
        if (cfg_we && cfg_sel == 2'd3) begin
            if (cfg_wdata[0]) c_d.st[cfg_stream].done = 1'b0;
            if (cfg_wdata[1]) c_d.st[cfg_stream].ovr  = 1'b0;
        end
        for (int s = 0; s < NSTR; s++) begin
            if (take[s] && !fpush[s]) c_d.st[s].ovr = 1'b1;
        end
        if (fire) begin
            c_d.st[c_q.gnt].addr = c_q.st[c_q.gnt].addr + AW'(4);
            c_d.st[c_q.gnt].cnt  = c_q.st[c_q.gnt].cnt - 1'b1;
            c_d.left             = c_q.left - 1'b1;
            if (c_q.left == LW'(1)) c_d.busy = 1'b0;
            if (c_q.st[c_q.gnt].cnt == CW'(1)) begin
                c_d.st[c_q.gnt].done = 1'b1;
                c_d.st[c_q.gnt].en   = 1'b0;
                c_d.busy             = 1'b0;
            end
        end
        if (!c_q.busy && arb_any) begin
            c_d.busy = 1'b1;
            c_d.gnt  = arb_idx;
            c_d.left = burst[arb_idx];
        end
        if (cfg_we) begin
            case (cfg_sel)
                2'd0: begin
                    c_d.st[cfg_stream].en   = cfg_wdata[0];
                    c_d.st[cfg_stream].chan = cfg_wdata[CHW:1];
                    c_d.st[cfg_stream].thr  = cfg_wdata[5:4];
                end
                2'd1:    c_d.st[cfg_stream].addr = cfg_wdata[AW-1:0];
                2'd2:    c_d.st[cfg_stream].cnt  = cfg_wdata[CW-1:0];
                default: ;
            endcase
        end
        if (c_d.busy && !c_d.st[c_d.gnt].en) c_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    dma_prio_arbiter #(.N(NSTR)) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (c_q.busy ? '0 : req),
        .gnt_oh  (arb_oh),
        .gnt_idx (arb_idx),
        .gnt_any (arb_any)
    );

    for (genvar s = 0; s < NSTR; s++) begin : g_stream
        dma_stream_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (fflush[s]),
            .push  (fpush[s]),
            .pop   (fpop[s]),
            .wdata (inword[s]),
            .rdata (head[s]),
            .level (lvl[s])
        );
        assign stream_en[s]      = c_q.st[s].en;
        assign stream_done[s]    = c_q.st[s].done;
        assign stream_overrun[s] = c_q.st[s].ovr;

        p_done_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(stream_done[s]) && !$past(cfg_we)) |-> !stream_en[s]);
        p_idle_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !stream_en[s] |-> !(mem_valid && mem_stream == SW'(s)));
    end

    assign per_ready  = claimed;
    assign mem_valid  = c_q.busy;
    assign mem_stream = c_q.gnt;
    assign mem_addr   = c_q.st[c_q.gnt].addr;
    assign mem_data   = head[c_q.gnt];

    p_stall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && !cfg_we) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_stream)));
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && c_q.left != LW'(1) &&
         c_q.st[c_q.gnt].cnt != CW'(1) && !cfg_we) |=>
            (mem_valid && mem_stream == $past(mem_stream) &&
             mem_addr == $past(mem_addr) + AW'(4)));
endmodule

// File: tb/test_dma_sched.sv
`timescale 1ns/1ps
module test_dma_sched;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_we;
    logic [2:0]   cfg_stream;
    logic [1:0]   cfg_sel;
    logic [31:0]  cfg_wdata;
    logic [7:0]   per_valid;
    logic [255:0] per_data;
    logic [7:0]   per_ready;
    logic         mem_valid, mem_ready;
    logic [31:0]  mem_addr, mem_data;
    logic [2:0]   mem_stream;
    logic [7:0]   stream_en, stream_done, stream_overrun;

    int checks = 0;
    int fails  = 0;
    int log_n  = 0;
    logic [31:0] log_a [256];
    logic [31:0] log_d [256];
    logic [2:0]  log_s [256];

    always #5 clk = ~clk;

    dma_sched i_dma_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stream(cfg_stream),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .per_valid(per_valid),
        .per_data(per_data), .per_ready(per_ready), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_stream(mem_stream), .stream_en(stream_en),
        .stream_done(stream_done), .stream_overrun(stream_overrun)
    );

    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready && log_n < 256) begin
            log_a[log_n] = mem_addr;
            log_d[log_n] = mem_data;
            log_s[log_n] = mem_stream;
            log_n++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg(input int s, input int sel, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_stream = 3'(s); cfg_sel = 2'(sel); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int s, input int ch, input int thr, input logic [31:0] a, input int n);
        cfg(s, 1, a);
        cfg(s, 2, 32'(n));
        cfg(s, 0, {26'd0, 2'(thr), 3'(ch), 1'b1});
    endtask

    task automatic push(input int ch, input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            per_valid[ch] = 1'b1;
            per_data[ch*32 +: 32] = base + 32'(i);
        end
        @(posedge clk); #1;
        per_valid[ch] = 1'b0;
    endtask

    task automatic expect_log(input int from, input int n, input logic [31:0] a0,
                              input logic [31:0] d0, input int s, input string tag);
        for (int i = 0; i < n; i++) begin
            check(log_a[from+i] == a0 + 32'(4*i), {tag, " addr"}, log_a[from+i], a0 + 32'(4*i));
            check(log_d[from+i] == d0 + 32'(i),   {tag, " data"}, log_d[from+i], d0 + 32'(i));
            check(log_s[from+i] == 3'(s),         {tag, " stream"}, 32'(log_s[from+i]), 32'(s));
        end
    endtask

    task automatic t_reset;
        check(mem_valid == 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
        check(per_ready == 8'h00, "R1 per_ready", 32'(per_ready), 0);
        check(stream_en == 8'h00, "R1 stream_en", 32'(stream_en), 0);
        check(stream_done == 8'h00 && stream_overrun == 8'h00, "R1 flags",
              {16'd0, stream_done, stream_overrun}, 0);
    endtask

    task automatic t_threshold_half;
        int b;
        mem_ready = 1'b1;
        setup(3, 5, 1, 32'h1000, 8);
        settle(1);
        check(per_ready == 8'h20, "R2 ready map", 32'(per_ready), 32'h20);
        b = log_n;
        push(5, 32'hA0, 3);
        settle(8);
        check(log_n == b, "R4 below threshold", 32'(log_n - b), 0);
        push(5, 32'hA3, 1);
        settle(8);
        check(log_n == b + 4, "R4 burst of four", 32'(log_n - b), 4);
        expect_log(b, 4, 32'h1000, 32'hA0, 3, "R6 first burst");
        push(5, 32'hA4, 4);
        settle(10);
        check(log_n == b + 8, "R7 total words", 32'(log_n - b), 8);
        expect_log(b + 4, 4, 32'h1010, 32'hA4, 3, "R6 second burst");
        check(stream_done[3] && !stream_en[3], "R7 done and disabled",
              {30'd0, stream_done[3], stream_en[3]}, 32'h2);
        check(per_ready == 8'h00, "R9 ready dropped", 32'(per_ready), 0);
        cfg(3, 3, 32'h1);
        settle(1);
        check(stream_done[3] == 1'b0, "R8 done w1c", 32'(stream_done[3]), 0);
    endtask

    task automatic t_priority;
        int b;
        mem_ready = 1'b1;
        setup(6, 1, 0, 32'h3000, 2);
        setup(1, 0, 0, 32'h2000, 2);
        b = log_n;
        for (int i = 0; i < 2; i++) begin
            @(posedge clk); #1;
            per_valid[1:0] = 2'b11;
            per_data[31:0]  = 32'hC0 + 32'(i);
            per_data[63:32] = 32'hD0 + 32'(i);
        end
        @(posedge clk); #1;
        per_valid[1:0] = 2'b00;
        settle(12);
        check(log_n == b + 4, "R3 word count", 32'(log_n - b), 4);
        expect_log(b, 2, 32'h2000, 32'hC0, 1, "R3 low stream first");
        expect_log(b + 2, 2, 32'h3000, 32'hD0, 6, "R5 high stream after");
        cfg(1, 3, 32'h1);
        cfg(6, 3, 32'h1);
    endtask

    task automatic t_three_quarter;
        int b;
        mem_ready = 1'b1;
        setup(0, 6, 3, 32'h5000, 6);
        b = log_n;
        push(6, 32'hE0, 5);
        settle(8);
        check(log_n == b, "R4 code 11 waits", 32'(log_n - b), 0);
        push(6, 32'hE5, 1);
        settle(12);
        check(log_n == b + 6, "R4 code 11 six words", 32'(log_n - b), 6);
        expect_log(b, 6, 32'h5000, 32'hE0, 0, "R6 six burst");
    endtask

    task automatic t_overrun_flush;
        int b;
        mem_ready = 1'b0;
        setup(4, 2, 2, 32'h6000, 16);
        b = log_n;
        push(2, 32'h50, 9);
        settle(2);
        check(stream_overrun[4] == 1'b1, "R8 overrun set", 32'(stream_overrun[4]), 1);
        check(mem_valid && mem_stream == 3'd4, "R5 stalled grant", {28'd0, mem_valid, mem_stream}, 32'hC);
        @(posedge clk); #1;
        mem_ready = 1'b1;
        settle(10);
        check(log_n == b + 6, "R4 code 10 six words", 32'(log_n - b), 6);
        expect_log(b, 6, 32'h6000, 32'h50, 4, "R8 kept words");
        check(stream_overrun[4] == 1'b1, "R8 sticky", 32'(stream_overrun[4]), 1);
        cfg(4, 3, 32'h2);
        settle(1);
        check(stream_overrun[4] == 1'b0, "R8 overrun w1c", 32'(stream_overrun[4]), 0);
        cfg(4, 0, 32'h24);
        settle(1);
        check(per_ready[2] == 1'b0, "R9 disabled not ready", 32'(per_ready[2]), 0);
        b = log_n;
        push(2, 32'h70, 6);
        settle(6);
        check(log_n == b, "R9 disabled no writes", 32'(log_n - b), 0);
        setup(4, 2, 0, 32'h7000, 2);
        push(2, 32'hB0, 2);
        settle(8);
        check(log_n == b + 2, "R9 after reenable", 32'(log_n - b), 2);
        expect_log(b, 2, 32'h7000, 32'hB0, 4, "R9 flushed old words");
    endtask

    task automatic t_fill_while_drain;
        int b;
        mem_ready = 1'b1;
        setup(5, 3, 1, 32'h8000, 8);
        b = log_n;
        push(3, 32'h90, 8);
        settle(14);
        check(log_n == b + 8, "R10 all words", 32'(log_n - b), 8);
        expect_log(b, 8, 32'h8000, 32'h90, 5, "R10 order");
        check(stream_done[5] == 1'b1, "R10 done", 32'(stream_done[5]), 1);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_stream = '0; cfg_sel = '0; cfg_wdata = '0;
        per_valid = '0; per_data = '0; mem_ready = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        settle(1);
        t_reset;
        t_threshold_half;
        t_priority;
        t_three_quarter;
        t_overrun_flush;
        t_fill_while_drain;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule